// File: doc/BRIEF.md
# TDM Timeslot Interchange with Broadcast and Bypass

This block reorders the byte channels of a framed time-division stream. Each clock cycle carries one 8-bit timeslot, and a frame-start pulse marks timeslot 0 of every frame. For every output timeslot a connection table names the input timeslot that feeds it. Switched bytes are held in a rotating set of frame banks and leave the block a fixed three frames after they arrived. Because several table entries may name the same source, one input channel can be copied onto many outputs.

Each table entry can also select a bypass path. A bypass output carries the input byte of the same timeslot in the same frame, with no frame delay. An entry that is not enabled produces the idle byte 0xFF. The table is written through a simple host write port into a shadow copy. The shadow is moved into the live table only on a frame start, so no frame is ever switched with a mix of old and new mappings.

Top module: `tdm_slot_switch`

## Requirements
- R1: After reset, and until the first frame start, tx_byte is 0xFF. All table entries reset to disabled, so every output of the first frame is 0xFF.
- R2: frame_start marks timeslot 0, and each following cycle is the next timeslot. The output byte for timeslot s appears on tx_byte in the cycle after rx_byte for timeslot s is presented.
- R3: An entry written as enable=1, bypass=0, source=k makes output timeslot s of frame f carry the byte received in timeslot k of frame f-3.
- R4: Frames are counted from 0, starting at the first frame start after reset. In frames 0, 1 and 2, a switched output (enable=1, bypass=0) carries 0xFF.
- R5: An entry with enable=1 and bypass=1 makes the output carry the rx_byte of that same timeslot in the same frame. The source field is ignored.
- R6: Several entries that name the same source timeslot all carry that source's byte in the same frame.
- R7: An entry with enable=0 makes its output carry 0xFF, whatever its other fields hold.
- R8: A host write to the table takes effect at the first frame start that follows the write cycle. This includes a write made in the frame-start cycle itself. The frame in progress keeps its old mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timeslot clock, one timeslot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | High in the cycle that carries timeslot 0 |
| rx_byte | input | 8 | Input byte of the current timeslot |
| cfg_we | input | 1 | Host write strobe for the connection table |
| cfg_slot | input | 5 | Output timeslot whose entry is written |
| cfg_src | input | 5 | Source input timeslot for that output |
| cfg_en | input | 1 | Entry enable; 0 selects the idle byte |
| cfg_byp | input | 1 | Entry bypass; 1 selects the same-slot input with no frame delay |
| tx_byte | output | 8 | Output byte, one cycle behind the timeslot |

## Verification
The bench targets the boundary between warm-up and live data. A design that counted frames wrongly, or picked the wrong bank, would show data one frame early or late, or stale bytes during frames 0 to 2. Table writes are placed in the middle of a frame and in the frame-start cycle. A design that let a write act at once would switch part of a frame with the new mapping. Bypass slots carry the current frame's byte, so a design that routed them through the banks would be three frames late. The bench also runs a full-frame reversal and a many-to-one broadcast to catch wrong source indexing. It disables entries whose other fields hold live values, which exposes a design that looks at bypass or source before the enable.

// File: rtl/tdm_slot_switch.sv
`timescale 1ns/1ps
module tdm_slot_switch #(
  parameter int SLOTS = 32,
  parameter int W     = 8,
  parameter int DELAY = 3,
  parameter int AW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic [W-1:0]  rx_byte,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_slot,
  input  logic [AW-1:0] cfg_src,
  input  logic          cfg_en,
  input  logic          cfg_byp,
  output logic [W-1:0]  tx_byte
);
  localparam int BANKS = DELAY + 1;
  localparam int BW    = (BANKS > 1) ? $clog2(BANKS) : 1;
  localparam int FW    = $clog2(DELAY + 1);
  localparam int EW    = AW + 2;
  localparam logic [W-1:0] IDLE = {W{1'b1}};

  logic          started;
  logic [AW-1:0] slot_q;
  logic [BW-1:0] bank_q;
  logic [FW-1:0] fidx_q;
  logic [W-1:0]  mem [BANKS][SLOTS];
  logic [EW-1:0] shadow [SLOTS];
  logic [EW-1:0] active [SLOTS];

  logic          live;
  logic [AW-1:0] cur_slot;
  logic [BW-1:0] cur_bank, rd_bank;
  logic [FW-1:0] cur_fidx;
  logic [EW-1:0] entry;
  logic          ent_en, ent_byp;
  logic [AW-1:0] ent_src;

  assign live     = started | frame_start;
  assign cur_slot = frame_start ? '0 :
                    (slot_q == AW'(SLOTS - 1)) ? '0 : slot_q + 1'b1;
  assign cur_bank = (frame_start && started) ?
                    ((bank_q == BW'(BANKS - 1)) ? '0 : bank_q + 1'b1) : bank_q;
  assign rd_bank  = (cur_bank == BW'(BANKS - 1)) ? '0 : cur_bank + 1'b1;
  assign cur_fidx = !frame_start ? fidx_q :
                    !started ? '0 :
                    (fidx_q == FW'(DELAY)) ? fidx_q : fidx_q + 1'b1;
  assign entry    = frame_start ? shadow[cur_slot] : active[cur_slot];
  assign ent_en   = entry[AW+1];
  assign ent_byp  = entry[AW];
  assign ent_src  = entry[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started <= 1'b0;
      slot_q  <= '0;
      bank_q  <= '0;
      fidx_q  <= '0;
      tx_byte <= IDLE;
    end else begin
      if (frame_start) started <= 1'b1;
      if (live) begin
        slot_q <= cur_slot;
        bank_q <= cur_bank;
        fidx_q <= cur_fidx;
      end
      if (!live || !ent_en)           tx_byte <= IDLE;
      else if (ent_byp)               tx_byte <= rx_byte;
      else if (cur_fidx != FW'(DELAY)) tx_byte <= IDLE;
      else                            tx_byte <= mem[rd_bank][ent_src];
    end
  end

  always_ff @(posedge clk) begin
    if (live) mem[cur_bank][cur_slot] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        shadow[i] <= '0;
        active[i] <= '0;
      end
    end else begin
      if (frame_start)
        for (int i = 0; i < SLOTS; i++) active[i] <= shadow[i];
      if (cfg_we && ({1'b0, cfg_slot} < (AW+1)'(SLOTS)))
        shadow[cfg_slot] <= {cfg_en, cfg_byp, cfg_src};
    end
  end

  assert_prestart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!started && !frame_start) |=> tx_byte == IDLE);

  assert_bank_turn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (started && frame_start) |=> bank_q != $past(bank_q));

  assert_warmup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && ent_en && !ent_byp && fidx_q != FW'(DELAY) && !frame_start) |=> tx_byte == IDLE);

  assert_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && ent_en && ent_byp) |=> tx_byte == $past(rx_byte));

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !ent_en) |=> tx_byte == IDLE);

  for (genvar g = 0; g < SLOTS; g++) begin : g_frozen
    assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(active[g]));
  end
endmodule

// File: tb/tdm_slot_switch_test.sv
`timescale 1ns/1ps
module tdm_slot_switch_test;
  localparam int SLOTS = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_slot = '0;
  logic [4:0] cfg_src = '0;
  logic cfg_en = 1'b0;
  logic cfg_byp = 1'b0;
  logic [7:0] tx_byte;

  tdm_slot_switch uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rx_byte(rx_byte),
    .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_src(cfg_src),
    .cfg_en(cfg_en), .cfg_byp(cfg_byp), .tx_byte(tx_byte)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int gf = 0;

  bit sh_en [SLOTS], sh_byp [SLOTS], ac_en [SLOTS], ac_byp [SLOTS];
  int sh_src [SLOTS], ac_src [SLOTS];

  int pw_n = 0, pw_i = 0, pw_at = 0;
  int pw_slot [64], pw_src [64];
  bit pw_en [64], pw_byp [64];

  function automatic logic [7:0] dat(int f, int s);
    return 8'((f * 29 + s * 7 + 1) % 255);
  endfunction

  task automatic check(logic [7:0] got, logic [7:0] exp, string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: tx_byte=%02h expected %02h (frame %0d)", req, got, exp, gf);
    end
  endtask

  task automatic qw(int slot, bit en, bit byp, int src);
    pw_slot[pw_n] = slot; pw_en[pw_n] = en; pw_byp[pw_n] = byp; pw_src[pw_n] = src;
    pw_n++;
  endtask

  task automatic run_frame(string tag);
    for (int s = 0; s < SLOTS; s++) begin
      logic [7:0] exp;
      string req;
      @(negedge clk);
      frame_start = (s == 0);
      rx_byte = dat(gf, s);
      if (s == 0)
        for (int i = 0; i < SLOTS; i++) begin
          ac_en[i] = sh_en[i]; ac_byp[i] = sh_byp[i]; ac_src[i] = sh_src[i];
        end
      if (s >= pw_at && pw_i < pw_n) begin
        cfg_we = 1'b1; cfg_slot = 5'(pw_slot[pw_i]); cfg_src = 5'(pw_src[pw_i]);
        cfg_en = pw_en[pw_i]; cfg_byp = pw_byp[pw_i];
        sh_en[pw_slot[pw_i]] = pw_en[pw_i]; sh_byp[pw_slot[pw_i]] = pw_byp[pw_i];
        sh_src[pw_slot[pw_i]] = pw_src[pw_i];
        pw_i++;
      end else cfg_we = 1'b0;
      if (!ac_en[s]) begin exp = 8'hFF; req = (gf == 0) ? "R1" : "R7"; end
      else if (ac_byp[s]) begin exp = dat(gf, s); req = "R5"; end
      else if (gf < 3) begin exp = 8'hFF; req = "R4"; end
      else begin exp = dat(gf - 3, ac_src[s]); req = tag; end
      @(posedge clk);
      #2;
      check(tx_byte, exp, req);
    end
    gf++;
    pw_n = 0; pw_i = 0; pw_at = 0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rx_byte = 8'(8'h10 + i);
      @(posedge clk);
      #2;
      check(tx_byte, 8'hFF, "R1");
    end
  endtask

  task automatic t_reverse_warmup;
    for (int s = 0; s < SLOTS; s++) qw(s, 1'b1, 1'b0, SLOTS - 1 - s);
    pw_at = 0;
    for (int k = 0; k < 5; k++) run_frame("R2");
  endtask

  task automatic t_broadcast;
    for (int s = 0; s < 16; s++) qw(s, 1'b1, 1'b0, 9);
    run_frame("R6");
    run_frame("R6");
  endtask

  task automatic t_bypass;
    for (int s = 0; s < SLOTS; s += 2) qw(s, 1'b1, 1'b1, (s * 5) % SLOTS);
    run_frame("R5");
    run_frame("R5");
  endtask

  task automatic t_disable;
    for (int s = 3; s <= 10; s++) qw(s, 1'b0, s[0], s + 4);
    run_frame("R7");
    run_frame("R7");
  endtask

  task automatic t_midframe_remap;
    for (int s = 16; s < SLOTS; s++) qw(s, 1'b1, 1'b0, s - 16);
    pw_at = 12;
    run_frame("R8");
    run_frame("R8");
    run_frame("R3");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_reverse_warmup;
    t_broadcast;
    t_bypass;
    t_disable;
    t_midframe_remap;
    @(negedge clk);
    frame_start = 1'b0;
    cfg_we = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule